// File: doc/BRIEF.md
# Run-time Formatted Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single line. Each frame is shaped by a set of line-format inputs: the character length (5 to 8 bits), the stop-bit length, whether a parity bit is sent, and the parity rule (odd, even or a fixed value). A break input holds the line at the spacing level without disturbing the frame timing inside the block. The bit rate comes from an external tick strobe that runs at sixteen times the bit rate.

Bytes arrive through a valid/ready handshake into a single-entry holding register. A frame sequencer takes the byte from there into its shift register, together with a snapshot of the format inputs. It frees the holding register as soon as the frame begins, so the producer can offer the next byte while the current frame is still on the line. When a frame ends and a byte is waiting, the next start bit follows at once. Two flags report whether the holding register is free and whether the whole transmitter is idle.

Top module: `uart_frame_tx`

## Requirements
- R1: The line rests at 1. A frame opens with one start bit at 0, followed by the data bits, least significant bit first. Word-length code 00 sends 5 data bits, 01 sends 6, 10 sends 7 and 11 sends 8. A 5, 6 or 7 bit word takes the low bits of the byte.
- R2: Each start, data and parity bit lasts TICKS_PER_BIT (16) tick strobes. Only strobes that arrive while a frame is in progress count.
- R3: With stop select low, the stop element lasts 16 ticks. With it high, the stop element lasts 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words.
- R4: With parity enable high, exactly one parity bit sits between the last data bit and the stop element. With parity enable low, no parity bit is sent, whatever the other parity inputs hold.
- R5: With parity enable high and stick low, the data bits plus the parity bit hold an even count of ones when even-select is 1 and an odd count when it is 0.
- R6: With parity enable and stick both high, the parity bit is 0 when even-select is 1 and 1 when even-select is 0. With stick low, the parity follows R5.
- R7: While break is high, the line is 0. The frame in progress keeps its full duration internally, and the transmitter-empty flag rises when that duration ends.
- R8: in_ready is high exactly when the holding register is free. A byte offered while in_ready is low is not taken and never appears on the line.
- R9: The holding register is freed on the clock edge that begins the frame, which is the same edge on which the line falls to the start bit. A waiting byte starts directly after the previous stop element, with no idle gap.
- R10: tx_empty is high only when the holding register is free and no frame is in progress. After reset, tx_empty, hold_empty and in_ready are 1 and the line is 1.
- R11: The format inputs are sampled when a frame begins. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Holding register can take a byte |
| wlen_code | input | 2 | Word length: 00=5, 01=6, 10=7, 11=8 bits |
| stop_sel | input | 1 | Long stop element (1.5 or 2 bits) |
| par_en | input | 1 | Send a parity bit |
| par_even | input | 1 | Even parity (1) or odd parity (0) |
| par_stick | input | 1 | Fixed parity value, chosen by par_even |
| brk | input | 1 | Force the line to 0 |
| line_out | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register and shifter are both idle |

## Verification
A sequencer that leaves a state too early or too late puts the wrong level on the line within one bit time, and the whole frame is then compared tick by tick against a model. Stop-element errors show up in two ways. A stop that is too short lets the next start bit arrive early. A stop that is too long delays tx_empty past the tick where the model closes the frame. A stale format snapshot or a wrong parity precomputation corrupts the one bit slot it drives, within that frame. A lost or duplicated holding entry shows up at the next frame as a byte that does not match the queue.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       long_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  // Index of the last data bit for a word-length code (4..7)
  function automatic logic [2:0] last_data_idx(input logic [1:0] code);
    return 3'(3'd4 + {1'b0, code});
  endfunction

  // Length of the stop element in tick strobes
  function automatic int unsigned stop_len(input frame_cfg_t c, input int unsigned tpb);
    if (!c.long_stop)       return tpb;
    else if (c.wlen == 2'b00) return tpb + tpb / 2;
    else                    return 2 * tpb;
  endfunction

  // Keep only the bits that the word length sends
  function automatic logic [BYTE_W-1:0] word_mask(input logic [1:0] code);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = (i <= int'(last_data_idx(code)));
    return m;
  endfunction

  // Parity bit value for a byte under a format
  function automatic logic parity_of(input logic [BYTE_W-1:0] d, input frame_cfg_t c);
    logic ones_odd;
    ones_odd = ^(d & word_mask(c.wlen));
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic [W-1:0] hold_data,
  output logic         hold_full
);

  logic accept;

  assign in_ready = ~hold_full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (accept) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R8: a full entry that is not taken keeps its byte
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));

  // R9: a taken entry is free on the next cycle
  p_take_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && take) |=> !hold_full);

  // R8: take never fires on an empty entry
  p_no_take_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_frame_pkg::*;
#(
  parameter int unsigned TPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_data,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              ser_bit,
  output logic              busy
);

  localparam int unsigned CW = $clog2(2 * TPB + 1);

  tx_state_e         state;
  logic [CW-1:0]     tick_cnt;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              par_q;
  frame_cfg_t        cfg_q;

  logic [CW-1:0]     dur;
  logic [2:0]        last_idx;
  logic              bit_end;
  logic              stop_end;

  assign last_idx = last_data_idx(cfg_q.wlen);
  assign dur      = (state == ST_STOP) ? CW'(stop_len(cfg_q, TPB)) : CW'(TPB);
  assign bit_end  = tick && (state != ST_IDLE) && (tick_cnt == dur - 1'b1);
  assign stop_end = bit_end && (state == ST_STOP);
  assign take     = hold_full && ((state == ST_IDLE) || stop_end);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START:  ser_bit = 1'b0;
      ST_DATA:   ser_bit = shreg[0];
      ST_PARITY: ser_bit = par_q;
      default:   ser_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      cfg_q    <= '0;
    end else if (take) begin
      state    <= ST_START;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= hold_data;
      par_q    <= parity_of(hold_data, cfg);
      cfg_q    <= cfg;
    end else if (tick && state != ST_IDLE) begin
      if (bit_end) begin
        tick_cnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == last_idx) state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end
          ST_PARITY: state <= ST_STOP;
          default:   state <= ST_IDLE;
        endcase
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  // R1: the start slot always drives space
  p_start_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |-> (ser_bit == 1'b0));

  // R3: the stop slot always drives mark
  p_stop_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> ser_bit);

  // R2: the tick counter stays inside the current slot
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick_cnt < dur));

  // R1: the data index never passes the word length
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bit_idx <= last_idx));

  // R4: the parity slot is entered only with parity enabled
  p_parity_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARITY) |-> cfg_q.par_en);

  // R9: a take always opens a new frame at the start slot
  p_take_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (state == ST_START));

  // R11: the snapshot holds for the whole frame
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> $stable(cfg_q));

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic ser_bit,
  output logic line_out
);

  assign line_out = ser_bit & ~brk;

  // R7: break holds the line at space
  p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !line_out);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  wlen_code,
  input  logic        stop_sel,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        brk,
  output logic        line_out,
  output logic        hold_empty,
  output logic        tx_empty
);

  logic              take;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              ser_bit;
  logic              busy;
  frame_cfg_t        cfg;

  assign cfg = '{wlen: wlen_code, long_stop: stop_sel, par_en: par_en,
                 par_even: par_even, par_stick: par_stick};

  uart_tx_hold #(.W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  uart_tx_seq #(.TPB(TICKS_PER_BIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg       (cfg),
    .take      (take),
    .ser_bit   (ser_bit),
    .busy      (busy)
  );

  uart_tx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk      (brk),
    .ser_bit  (ser_bit),
    .line_out (line_out)
  );

  assign hold_empty = ~hold_full;
  assign tx_empty   = ~hold_full & ~busy;

  // R10: an idle transmitter shows mark unless break is held
  p_idle_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> line_out);

  // R10: transmitter empty implies a free holding register
  p_empty_implies_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] wlen_code = 2'b11;
  logic       stop_sel = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       brk = 1'b0;
  logic       line_out;
  logic       hold_empty;
  logic       tx_empty;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .wlen_code(wlen_code),
    .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .line_out(line_out),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // Tick strobe: one cycle in three
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv   <= (tdiv == 2) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 2);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int n; bit stp; bit pe; bit ev; bit st; } fmt_t;

  function automatic fmt_t cur_fmt();
    fmt_t f;
    f.n = 5 + int'(wlen_code); f.stp = stop_sel; f.pe = par_en;
    f.ev = par_even; f.st = par_stick;
    return f;
  endfunction

  function automatic bit ref_parity(input logic [7:0] b, input fmt_t f);
    int ones = 0;
    for (int i = 0; i < f.n; i++) ones += b[i];
    if (f.st) return !f.ev;
    return f.ev ? (ones % 2 == 1) : (ones % 2 == 0);
  endfunction

  function automatic int ref_len(input fmt_t f);
    int stop_t;
    stop_t = !f.stp ? TPB : (f.n == 5 ? (TPB * 3) / 2 : 2 * TPB);
    return TPB * (1 + f.n + (f.pe ? 1 : 0)) + stop_t;
  endfunction

  function automatic bit ref_level(input logic [7:0] b, input fmt_t f, input int t);
    int r = t;
    if (r < TPB) return 1'b0;
    r -= TPB;
    if (r < f.n * TPB) return b[r / TPB];
    r -= f.n * TPB;
    if (f.pe && r < TPB) return ref_parity(b, f);
    return 1'b1;
  endfunction

  // ---------------- line monitor ----------------
  logic [7:0] sent_q[$];
  bit   mon_en = 1'b0;
  bit   in_frame = 1'b0;
  int   tpos = 0;
  int   mism = 0;
  int   frames = 0;
  fmt_t mfmt;
  logic [7:0] mbyte;

  always @(negedge clk) begin
    if (mon_en) begin
      if (in_frame && tpos == ref_len(mfmt)) begin
        // R1 R2 R3 R4 R5 R6: whole frame waveform against the model
        chk(mism == 0, "R1 R2 R3 R4 R5 R6 frame waveform mismatches", mism, 0);
        if (sent_q.size() == 0)  // R10 R3: frame length ends exactly here
          chk(tx_empty == 1'b1, "R10 R3 tx_empty at frame end", int'(tx_empty), 1);
        in_frame = 1'b0;
        frames++;
      end
      if (!in_frame && line_out == 1'b0 && !brk) begin
        if (sent_q.size() == 0) begin
          chk(1'b0, "R8 unexpected frame start", 1, 0);
        end else begin
          mbyte = sent_q.pop_front();
          mfmt = cur_fmt();
          tpos = 0;
          mism = 0;
          in_frame = 1'b1;
          // R9: holding register freed on the edge the start bit began
          chk(hold_empty == 1'b1, "R9 hold_empty at start bit", int'(hold_empty), 1);
        end
      end
      if (in_frame) begin
        if (line_out !== ref_level(mbyte, mfmt, tpos)) mism++;
        if (tick16) tpos++;
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = b;
    in_valid = 1'b1;
    sent_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] wl, input bit sp, input bit pe,
                         input bit ev, input bit st);
    wlen_code = wl; stop_sel = sp; par_en = pe; par_even = ev; par_stick = st;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    int seed;
    seed = $urandom(32'd7301);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 R8: reset state
    chk(line_out == 1'b1, "R10 line idle after reset", int'(line_out), 1);
    chk(tx_empty == 1'b1, "R10 tx_empty after reset", int'(tx_empty), 1);
    chk(hold_empty == 1'b1, "R10 hold_empty after reset", int'(hold_empty), 1);
    chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
    mon_en = 1'b1;

    // Directed: every word length, stop select and parity mode
    // (pe,ev,st): off, odd, even, stick-1, stick-0, stick without enable
    for (int wl = 0; wl < 4; wl++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int pm = 0; pm < 6; pm++) begin
          case (pm)
            0: set_fmt(2'(wl), 1'(sp), 1'b0, 1'b0, 1'b0);
            1: set_fmt(2'(wl), 1'(sp), 1'b1, 1'b0, 1'b0);
            2: set_fmt(2'(wl), 1'(sp), 1'b1, 1'b1, 1'b0);
            3: set_fmt(2'(wl), 1'(sp), 1'b1, 1'b0, 1'b1);
            4: set_fmt(2'(wl), 1'(sp), 1'b1, 1'b1, 1'b1);
            default: set_fmt(2'(wl), 1'(sp), 1'b0, 1'b1, 1'b1);
          endcase
          send(8'(8'hA5 ^ (wl * 37 + sp * 11 + pm * 5)));
          drain();
        end
      end
    end

    // R8: a byte offered while the holding register is full is refused
    set_fmt(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'h3C);
    send(8'hC3);
    begin
      int rdy_seen = 0;
      @(negedge clk);
      in_data = 8'hFF;
      in_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (in_ready) rdy_seen++;
      end
      in_valid = 1'b0;
      chk(rdy_seen == 0, "R8 in_ready low while holding full", rdy_seen, 0);
      chk(hold_empty == 1'b0, "R8 hold_empty low while full", int'(hold_empty), 0);
    end
    drain();
    chk(sent_q.size() == 0, "R8 R9 all queued bytes sent", sent_q.size(), 0);

    // R11: format changes during a frame are ignored
    set_fmt(2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'h96);
    repeat (100) @(negedge clk);
    set_fmt(2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    drain();
    chk(in_frame == 1'b0, "R11 frame closed with snapshot format", int'(in_frame), 0);

    // R7: break holds line low while the frame keeps its timing
    set_fmt(2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
    begin
      fmt_t f;
      int ones = 0;
      int ticks = 0;
      f = cur_fmt();
      brk = 1'b1;
      mon_en = 1'b0;
      @(negedge clk);
      in_data = 8'h5A;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!tx_empty) begin
        if (line_out) ones++;
        if (tick16) ticks++;
        @(negedge clk);
      end
      chk(ones == 0, "R7 line stays low during break", ones, 0);
      chk(ticks >= ref_len(f) && ticks <= ref_len(f) + 1,
          "R7 frame timing kept under break", ticks, ref_len(f));
      brk = 1'b0;
      @(negedge clk);
      chk(line_out == 1'b1, "R7 line returns to mark after break", int'(line_out), 1);
      mon_en = 1'b1;
    end

    // Random batches, back-to-back frames (R9 no gap checked by waveform)
    for (int bt = 0; bt < 6; bt++) begin
      set_fmt(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
      for (int k = 0; k < 7; k++) send(8'($urandom_range(0, 255)));
      drain();
    end
    chk(frames == 48 + 2 + 1 + 42, "R1 R9 frame count", frames, 93);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule